// File: doc/BRIEF.md
# Right Barrel Shifter with Carry-Out

This block is the right-shift part of a 32-bit processor datapath. It takes an operand word and an 8-bit shift length. It returns the operand shifted right, either arithmetically or logically, together with a carry flag. When the flag update is enabled, the carry flag is the last bit shifted out. Otherwise the incoming carry passes through unchanged.

Shift lengths from 0 to 255 are all accepted, and none of them wraps back to a smaller amount. Any length at or beyond the word width gives a saturated result. A length of zero moves nothing and keeps the incoming carry. The shifter itself is combinational.

The shifter sits behind one register stage with valid/ready handshakes on both sides. An operation is taken in on a cycle where `in_valid` and `in_ready` are both high. Its result appears on the output one clock later with `out_valid` high. A result that has not been taken stays unchanged on the output until `out_ready` is high. While a result is waiting, `in_ready` is low, so the upstream side has to hold its request.

Top module: `shr_unit`

## Requirements
- R1: With `in_arith`=0 (logical) and 1 ≤ n ≤ 31, the result equals the operand shifted right by n, with zeros filling the top n bits.
- R2: With `in_arith`=1 (arithmetic) and 1 ≤ n ≤ 31, the result equals the operand shifted right by n, with copies of operand bit 31 filling the top n bits.
- R3: With n = 0, the result equals the operand and the carry-out equals `in_carry`, whatever `in_setflags` is.
- R4: An arithmetic shift with n ≥ 32 gives a result in which every bit equals operand bit 31. If `in_setflags`=1, the carry-out also equals operand bit 31.
- R5: A logical shift with n ≥ 32 gives a zero result.
- R6: A logical shift with `in_setflags`=1 gives a carry-out equal to operand bit 31 when n = 32, and 0 when n > 32.
- R7: With `in_setflags`=1 and 1 ≤ n ≤ 31, the carry-out equals operand bit n-1, for either shift type.
- R8: With `in_setflags`=0, the carry-out equals `in_carry` for every shift length and shift type.
- R9: All eight bits of `in_amt` count toward the shift length. Lengths such as 33, 67, 129 and 255 saturate and are not reduced modulo 32.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and `out_carry` hold their values until the result is taken.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1. An accepted operation shows `out_valid`=1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Stage can accept an operation |
| in_data | input | 32 | Operand word |
| in_amt | input | 8 | Shift length, 0 to 255 |
| in_arith | input | 1 | 1 = arithmetic right shift, 0 = logical right shift |
| in_carry | input | 1 | Incoming carry flag |
| in_setflags | input | 1 | 1 = carry-out takes the last bit shifted out |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Shifted word |
| out_carry | output | 1 | Resulting carry flag |

## Verification
The hardest cases to reach are the lengths whose low five bits alias a small shift, for example 33, 67 and 129. A shifter that ignores the upper length bits would give a plausible but wrong answer on them. The stimulus therefore sweeps every length from 0 to 40 and also applies 255 and a set of aliasing lengths, each with random operands of both signs. The other hard point is the stall: a result is parked with `out_ready` low while a second request is pending behind it. This checks that the parked result does not change and that the pending request is taken only after release.

// File: rtl/shr_pkg.sv
package shr_pkg;
  // Shift type encoding on the in_arith pin
  typedef enum logic {
    SHK_LOGICAL = 1'b0,
    SHK_ARITH   = 1'b1
  } shift_kind_e;
endpackage

// File: rtl/shr_core.sv
// Logarithmic right shifter over an extended word {data, guard}.
// The guard bit lands on bit 0 after the shift: it is the last bit shifted out.
module shr_core #(
  parameter int W     = 32,
  parameter int LOG2W = $clog2(W)
) (
  input  logic [W-1:0]     data,
  input  logic [LOG2W-1:0] amt_lo,
  input  logic             fill,
  output logic [W:0]       ext_out
);
  logic [LOG2W:0][W:0] stg;

  assign stg[0] = {data, 1'b0};

  for (genvar g = 0; g < LOG2W; g++) begin : g_stage
    localparam int SH = 1 << g;
    assign stg[g+1] = amt_lo[g] ? {{SH{fill}}, stg[g][W:SH]} : stg[g];
  end

  assign ext_out = stg[LOG2W];
endmodule

// File: rtl/shr_carry.sv
// Picks the carry-out for the current operation.
module shr_carry (
  input  logic cin,
  input  logic setflags,
  input  logic arith,
  input  logic msb,
  input  logic amt_zero,
  input  logic big,
  input  logic amt_is_w,
  input  logic shifted_out,
  output logic cout
);
  always_comb begin
    if (!setflags || amt_zero) cout = cin;
    else if (!big)             cout = shifted_out;
    else if (arith)            cout = msb;
    else                       cout = amt_is_w ? msb : 1'b0;
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [AW-1:0] in_amt,
  input  logic          in_arith,
  input  logic          in_carry,
  input  logic          in_setflags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_carry
);
  localparam int LOG2W = $clog2(W);

  shift_kind_e kind;
  logic        fill, big, amt_zero, amt_is_w;
  logic [W:0]  ext;
  logic [W-1:0] res;
  logic        cout;
  logic        fire;

  assign kind     = shift_kind_e'(in_arith);
  assign fill     = (kind == SHK_ARITH) & in_data[W-1];
  assign big      = |in_amt[AW-1:LOG2W];
  assign amt_zero = (in_amt == '0);
  assign amt_is_w = (in_amt == AW'(W));

  shr_core #(.W(W), .LOG2W(LOG2W)) core_i (
    .data    (in_data),
    .amt_lo  (in_amt[LOG2W-1:0]),
    .fill    (fill),
    .ext_out (ext)
  );

  shr_carry carry_i (
    .cin         (in_carry),
    .setflags    (in_setflags),
    .arith       (kind == SHK_ARITH),
    .msb         (in_data[W-1]),
    .amt_zero    (amt_zero),
    .big         (big),
    .amt_is_w    (amt_is_w),
    .shifted_out (ext[0]),
    .cout        (cout)
  );

  assign res      = big ? {W{fill}} : ext[W:1];
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= res;
        out_carry <= cout;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic [AW-1:0] in_amt,
  input logic          in_arith,
  input logic          in_carry,
  input logic          in_setflags,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          out_carry
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R10: a parked result stays put and blocks new input
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_carry));
  a_r10_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R11: accepted operation shows up next cycle
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R3: zero length passes operand and carry
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_amt == '0 |=> out_data == $past(in_data) && out_carry == $past(in_carry));
  // R8: flags disabled keeps carry
  a_r8_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_setflags |=> out_carry == $past(in_carry));
  // R5: logical saturation
  a_r5_lsr_big: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_arith && in_amt >= AW'(W) |=> out_data == '0);
  // R4: arithmetic saturation
  a_r4_asr_big: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_arith && in_amt >= AW'(W) |=> out_data == {W{$past(in_data[W-1])}});
endmodule

bind shr_unit shr_unit_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_amt(in_amt), .in_arith(in_arith), .in_carry(in_carry),
  .in_setflags(in_setflags), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_carry(out_carry)
);

// File: tb/shr_unit_tb_top.sv
module shr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic [7:0]  in_amt;
  logic        in_arith, in_carry, in_setflags;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        out_carry;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  shr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amt(in_amt), .in_arith(in_arith), .in_carry(in_carry),
    .in_setflags(in_setflags), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_carry(out_carry)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent bitwise reference
  task automatic ref_model(input logic [31:0] d, input int n, input logic ar,
                           input logic ci, input logic sf,
                           output logic [31:0] r, output logic co);
    logic f;
    f = ar & d[31];
    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i+n] : f;
    if (!sf || n == 0) co = ci;
    else if (n <= 32)  co = d[n-1];
    else               co = f;
  endtask

  // Apply one operation at a negedge, check result one cycle later
  task automatic run_op(string req, logic [31:0] d, int n, logic ar, logic ci, logic sf);
    logic [31:0] er;
    logic ec;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_amt = 8'(n);
    in_arith = ar; in_carry = ci; in_setflags = sf;
    @(negedge clk);
    in_valid = 1'b0;
    ref_model(d, n, ar, ci, sf, er, ec);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " data"}, out_data, er);
    check({req, " carry"}, {31'd0, out_carry}, {31'd0, ec});
  endtask

  task automatic t_reset();
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_lsr_sweep();  // R1 R5 R6 R7
    for (int n = 0; n <= 40; n++) begin
      run_op("R1/R7 lsr", $urandom(), n, 1'b0, $urandom() % 2, 1'b1);
      run_op("R6 lsr neg", 32'h8000_0000 | $urandom(), n, 1'b0, 1'b0, 1'b1);
    end
    run_op("R5 lsr 255", 32'hFFFF_FFFF, 255, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_asr_sweep();  // R2 R4 R7
    for (int n = 0; n <= 40; n++) begin
      run_op("R2/R7 asr pos", $urandom() & 32'h7FFF_FFFF, n, 1'b1, $urandom() % 2, 1'b1);
      run_op("R2/R4 asr neg", 32'h8000_0000 | $urandom(), n, 1'b1, 1'b0, 1'b1);
    end
    run_op("R4 asr 255", 32'h8000_0001, 255, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_zero();  // R3
    run_op("R3 zero flags", 32'hDEAD_BEEF, 0, 1'b1, 1'b1, 1'b1);
    run_op("R3 zero carry0", 32'h8000_0001, 0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_noflag();  // R8
    for (int n = 0; n <= 40; n += 4) begin
      run_op("R8 noflag c1", 32'h0000_0000, n, 1'b0, 1'b1, 1'b0);
      run_op("R8 noflag c0", 32'hFFFF_FFFF, n, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_wrap();  // R9
    run_op("R9 len33 lsr", 32'hFFFF_FFFF, 33, 1'b0, 1'b1, 1'b1);
    run_op("R9 len67 lsr", 32'hF0F0_F0F0, 67, 1'b0, 1'b1, 1'b1);
    run_op("R9 len129 asr", 32'h9234_5678, 129, 1'b1, 1'b0, 1'b1);
    run_op("R9 len160 asr", 32'h1234_5678, 160, 1'b1, 1'b1, 1'b1);
    run_op("R9 len255 lsr", 32'h8000_0000, 255, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_backpressure();  // R10
    logic [31:0] ea, eb;
    logic c;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'hF000_000F; in_amt = 8'd4;
    in_arith = 1'b1; in_carry = 1'b0; in_setflags = 1'b1;
    ref_model(32'hF000_000F, 4, 1'b1, 1'b0, 1'b1, ea, c);
    ref_model(32'h1234_5678, 8, 1'b0, 1'b0, 1'b1, eb, c);
    @(negedge clk);
    check("R10 first result", out_data, ea);
    in_data = 32'h1234_5678; in_amt = 8'd8; in_arith = 1'b0;
    check("R10 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R10 data held", out_data, ea);
    check("R10 carry held", {31'd0, out_carry}, 32'd1);
    check("R10 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result after release", out_data, eb);
    check("R10 second carry", {31'd0, out_carry}, 32'd0);
    @(negedge clk);
    check("R11 drains", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_data = '0; in_amt = '0; in_arith = 1'b0; in_carry = 1'b0; in_setflags = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsr_sweep();
    t_asr_sweep();
    t_zero();
    t_noflag();
    t_wrap();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule